// File: doc/BRIEF.md
# Burst-Limited DMA Request Controller

This block runs the request/acknowledge handshake between a parallel-port byte FIFO and a host DMA controller. It raises a request while DMA is switched on, no service is pending and the FIFO can take part in a transfer in the current direction. Each acknowledge that arrives while the request is high produces one FIFO strobe. With the host-to-port direction that strobe is a push. With the port-to-host direction it is a pop. The acknowledge is the only thing that selects the FIFO, and no address takes part in the selection.

To keep the host bus available for memory refresh, the controller ends a run of back-to-back acknowledged cycles once it reaches a parameterised length (32 by default). It then holds the request low for a short rest before it asks again. A terminal count seen during an acknowledged cycle produces a one-cycle event. The surrounding logic uses that event to set the service-pending flag, and the raised flag stops any further requests until software clears it.

The controller has three states. `ST_IDLE` moves to `ST_BURST` on the clock after the transfer conditions are met. `ST_BURST` returns to `ST_IDLE` when the conditions lapse or a terminal count is acknowledged. It moves to `ST_REST` on the acknowledge that completes a full burst. `ST_REST` moves back to `ST_IDLE` after `REST_CYCLES` clocks.

Top module: `dma_burst_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `dreq` is low and none of `fifo_push`, `fifo_pop` and `tc_event` is asserted, whatever the other inputs are.
- R2: `dreq` is high only while `dma_enable`=1 and `svc_pending`=0. Clearing `dma_enable` or setting `svc_pending` drops `dreq` in the same cycle.
- R3: `dreq` is withheld while `dir_to_host`=0 and `fifo_full`=1, and while `dir_to_host`=1 and `fifo_empty`=1. The flag for the other direction has no effect.
- R4: A cycle with `dreq`=1 and `dack_n`=0 gives `fifo_push`=1 when `dir_to_host`=0 and `fifo_pop`=1 when `dir_to_host`=1. An acknowledge while `dreq` is low gives no strobe.
- R5: From idle, `dreq` rises on the clock after the transfer conditions hold, so it is low for the first cycle in which they hold.
- R6: At most 32 acknowledged cycles occur within one unbroken `dreq` high period. After the 32nd, `dreq` falls on the next clock and stays low for exactly 3 cycles if the conditions keep holding.
- R7: An acknowledged cycle with `tc`=1 pulses `tc_event` in that same cycle, and `dreq` is low in the following cycle.
- R8: The acknowledged-cycle count restarts whenever `dreq` goes low for any reason, so a later burst again gets the full 32 cycles.
- R9: After any falling edge, `dreq` stays low for at least two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dma_enable | input | 1 | DMA transfers switched on |
| svc_pending | input | 1 | Service pending; blocks requests when 1 |
| dir_to_host | input | 1 | 0: host fills FIFO, 1: FIFO drains to host |
| fifo_full | input | 1 | FIFO has no free entry |
| fifo_empty | input | 1 | FIFO holds no data |
| dack_n | input | 1 | DMA acknowledge, active low |
| tc | input | 1 | Terminal count from the host DMA controller |
| dreq | output | 1 | DMA request to the host |
| fifo_push | output | 1 | Write strobe into the FIFO |
| fifo_pop | output | 1 | Read strobe out of the FIFO |
| tc_event | output | 1 | One-cycle terminal-count event |

## Verification
The hardest case to reach is the counter restart of R8. A burst has to be broken part way through, by a condition drop rather than by the limit, and the run that follows must then be shown to get the full 32 cycles instead of the leftover. The stimulus acknowledges 20 cycles, clears `dma_enable` for a single cycle and then acknowledges continuously. It records the longest acknowledged run between `dreq` edges and checks that this run is exactly 32. The rest length after a limit-ended burst is measured the same way, by counting low cycles between `dreq` edges.

// File: rtl/dmarq_pkg.sv
package dmarq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_REST  = 2'd2
    } dmarq_state_t;

endpackage

// File: rtl/dmarq_qualify.sv
// Combinational qualification of the request and decode of the FIFO strobes.
module dmarq_qualify (
    input  logic dma_enable,
    input  logic svc_pending,
    input  logic dir_to_host,
    input  logic fifo_full,
    input  logic fifo_empty,
    input  logic in_burst,
    input  logic dack_n,
    input  logic tc,
    output logic ready,
    output logic dreq,
    output logic ack_hit,
    output logic push,
    output logic pop,
    output logic tc_hit
);

    logic fifo_can_move;

    always_comb begin
        // only the flag that matters for the current direction is looked at
        fifo_can_move = dir_to_host ? !fifo_empty : !fifo_full;
        ready         = dma_enable && !svc_pending && fifo_can_move;
        dreq          = in_burst && ready;
        // the acknowledge alone selects the FIFO
        ack_hit       = dreq && !dack_n;
        push          = ack_hit && !dir_to_host;
        pop           = ack_hit && dir_to_host;
        tc_hit        = ack_hit && tc;
    end

endmodule

// File: rtl/dmarq_counter.sv
// Up-counter with clear; flags the final count before wrap.
module dmarq_counter #(
    parameter int LIMIT = 32,
    localparam int W = $clog2(LIMIT + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count,
    output logic         last
);

    assign last = (count == W'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc) begin
            count <= last ? '0 : count + 1'b1;
        end
    end

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count < W'(LIMIT));

endmodule

// File: rtl/dma_burst_ctrl.sv
module dma_burst_ctrl #(
    parameter int MAX_BURST   = 32,
    parameter int REST_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dma_enable,
    input  logic svc_pending,
    input  logic dir_to_host,
    input  logic fifo_full,
    input  logic fifo_empty,
    input  logic dack_n,
    input  logic tc,
    output logic dreq,
    output logic fifo_push,
    output logic fifo_pop,
    output logic tc_event
);
    import dmarq_pkg::*;

    localparam int BW = $clog2(MAX_BURST + 1);
    localparam int RW = $clog2(REST_CYCLES + 1);

    dmarq_state_t state, nxt;
    logic          in_burst, in_rest;
    logic          ready, ack_hit;
    logic          burst_last, rest_last;
    logic [BW-1:0] burst_count;
    logic [RW-1:0] rest_count;

    dmarq_qualify u_qual (
        .dma_enable (dma_enable),
        .svc_pending(svc_pending),
        .dir_to_host(dir_to_host),
        .fifo_full  (fifo_full),
        .fifo_empty (fifo_empty),
        .in_burst   (in_burst),
        .dack_n     (dack_n),
        .tc         (tc),
        .ready      (ready),
        .dreq       (dreq),
        .ack_hit    (ack_hit),
        .push       (fifo_push),
        .pop        (fifo_pop),
        .tc_hit     (tc_event)
    );

    // acknowledged cycles in the current request period; restarts when dreq is low
    dmarq_counter #(.LIMIT(MAX_BURST)) u_burst (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (!dreq),
        .inc  (ack_hit),
        .count(burst_count),
        .last (burst_last)
    );

    // forced quiet time after a limit-ended burst
    dmarq_counter #(.LIMIT(REST_CYCLES)) u_rest (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (!in_rest),
        .inc  (in_rest),
        .count(rest_count),
        .last (rest_last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (ready) nxt = ST_BURST;
            ST_BURST: begin
                if (!dreq)                        nxt = ST_IDLE;
                else if (tc_event)                nxt = ST_IDLE;
                else if (ack_hit && burst_last)   nxt = ST_REST;
            end
            ST_REST:  if (rest_last) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // state decode for the datapath
    always_comb begin
        in_burst = (state == ST_BURST);
        in_rest  = (state == ST_REST);
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> !dreq && !fifo_push && !fifo_pop && !tc_event);

    // R3
    push_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> !fifo_full);

    // R3
    pop_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);

    // R6
    burst_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_hit && burst_last && !tc) |=> !dreq ##1 !dreq);

    // R7
    tc_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc_event |=> !dreq);

    // R9
    low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dreq) |=> !dreq);

    // R2
    gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dreq) && dreq |-> $past(dma_enable) && !$past(svc_pending));

endmodule

// File: tb/dma_burst_ctrl_test.sv
module dma_burst_ctrl_test;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, en, pend, dir, full, empty, dack_n, tc;
    logic dreq, push, pop, tce;

    dma_burst_ctrl uut (
        .clk(clk), .rst_n(rst_n), .dma_enable(en), .svc_pending(pend),
        .dir_to_host(dir), .fifo_full(full), .fifo_empty(empty),
        .dack_n(dack_n), .tc(tc), .dreq(dreq), .fifo_push(push),
        .fifo_pop(pop), .tc_event(tce)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;
    string tag = "R1";

    // reference model: phase 0 waiting, 1 requesting, 2 resting
    int m_phase = 0;
    int m_acks = 0;
    int m_rest = 0;

    // run observation
    int run_acks = 0, max_run = 0, low_run = 0, last_gap = 0;
    logic prev_dreq = 1'b0;

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ack_mode: 0 never, 1 answer the request, 2 always
    task automatic step(int ack_mode, bit tc_in = 1'b0);
        bit okm, e_dreq, a;
        @(negedge clk);
        okm    = en && !pend && (dir ? !empty : !full);
        e_dreq = (m_phase == 1) && okm;
        #1;
        dack_n = !((ack_mode == 2) || (ack_mode == 1 && dreq));
        tc     = tc_in;
        #2;
        a = !dack_n;
        chk(tag, "dreq", int'(dreq), int'(e_dreq));
        chk(tag, "push", int'(push), int'(e_dreq && a && !dir));
        chk(tag, "pop",  int'(pop),  int'(e_dreq && a && dir));
        chk(tag, "tc_event", int'(tce), int'(e_dreq && a && tc_in));
        if (dreq && !prev_dreq) last_gap = low_run;
        low_run = dreq ? 0 : low_run + 1;
        if (dreq && a) run_acks++;
        if (!dreq && prev_dreq) begin
            if (run_acks > max_run) max_run = run_acks;
            run_acks = 0;
        end
        prev_dreq = dreq;
        @(posedge clk);
        if (m_phase == 0) begin
            if (okm) m_phase = 1;
            m_acks = 0;
        end else if (m_phase == 1) begin
            if (!e_dreq || (a && tc_in)) begin
                m_phase = 0;
                m_acks = 0;
            end else if (a) begin
                m_acks++;
                if (m_acks == 32) begin
                    m_phase = 2;
                    m_rest = 0;
                    m_acks = 0;
                end
            end
        end else begin
            m_rest++;
            if (m_rest == 2) m_phase = 0;
        end
        #1;
        if (e_dreq && a && tc_in) pend = 1'b1;
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; en = 1'b1; pend = 1'b0; dir = 1'b0;
        full = 1'b0; empty = 1'b0; dack_n = 1'b0; tc = 1'b1;
        repeat (3) begin
            @(negedge clk); #3;
            tag = "R1";
            chk("R1", "dreq in reset", int'(dreq), 0);
            chk("R1", "strobes in reset", int'(push | pop | tce), 0);
        end
        en = 1'b0; dack_n = 1'b1; tc = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        step(0);
        chk("R1", "dreq after reset", int'(dreq), 0);

        // R5 and R6: continuous burst in the host-to-port direction
        tag = "R6"; en = 1'b1; dir = 1'b0; empty = 1'b1;
        for (int i = 0; i < 40; i++) step(1);
        chk("R6", "longest acked run", max_run, 32);
        chk("R6", "rest length", last_gap, 3);

        // R3: withheld by the relevant flag only (port-to-host)
        tag = "R3"; dir = 1'b1; empty = 1'b1; full = 1'b0;
        for (int i = 0; i < 4; i++) step(1);
        chk("R3", "dreq with empty fifo", int'(dreq), 0);
        empty = 1'b0;
        for (int i = 0; i < 6; i++) step(1);
        full = 1'b1;
        for (int i = 0; i < 4; i++) step(1);
        full = 1'b0;

        // R4: acknowledge while request is low gives nothing
        tag = "R4"; pend = 1'b1;
        for (int i = 0; i < 5; i++) step(2);
        chk("R4", "no pop on stray ack", int'(pop), 0);
        pend = 1'b0;
        for (int i = 0; i < 5; i++) step(1);

        // R2: enable gating
        tag = "R2";
        en = 1'b0;
        for (int i = 0; i < 3; i++) step(1);
        en = 1'b1;
        for (int i = 0; i < 4; i++) step(0);

        // R8: break a burst part way, then the next one gets 32
        tag = "R8"; dir = 1'b0;
        for (int i = 0; i < 6; i++) step(0);
        max_run = 0; run_acks = 0;
        for (int i = 0; i < 20; i++) step(1);
        en = 1'b0; step(1); en = 1'b1;
        for (int i = 0; i < 45; i++) step(1);
        chk("R8", "run after early break", max_run, 32);

        // R7: terminal count
        tag = "R7";
        for (int i = 0; i < 3; i++) step(1);
        step(1, 1'b1);
        chk("R7", "service flag set", int'(pend), 1);
        for (int i = 0; i < 4; i++) step(1);
        chk("R7", "dreq after tc", int'(dreq), 0);
        pend = 1'b0;
        tag = "R9";
        for (int i = 0; i < 6; i++) step(1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule